// File: doc/BRIEF.md
# Multi-Context Reservation Monitor

This block arbitrates load-reserved / store-conditional atomics for several hardware thread contexts that share one physical memory. Each context owns one reservation: a block address and a valid bit. A reserving load from a context records the block it touched. A later conditional store from the same context is allowed to write only if that reservation is still valid and names the same aligned 16-byte block. Every store that does reach memory, whether plain or conditional, cancels the reservations of all contexts that hold the written block.

The block takes at most one request per cycle and answers one cycle later with registered outputs. These outputs are a response strobe, a two-bit result, a memory write enable with its address, and a warning pulse. The pulse is raised for a context whose run of back-to-back conditional-store failures reaches a multiple of a configurable period. It lets software or a debug monitor spot an apparent livelock.

Top module: `resv_monitor`

## Requirements
- R1: After synchronous active-high reset, every reservation is invalid, every failure run is zero, and `rsp_valid`, `rsp_result`, `mem_we` and `warn_pulse` are 0.
- R2: Operation codes on `req_op` are 0 plain load, 1 reserving load, 2 plain store, 3 conditional store. A reserving load stores its address block in the issuing context's reservation and marks it valid. It returns result 0 and does not write.
- R3: Block comparison ignores the low 4 address bits, so any two addresses that differ only in bits [3:0] match.
- R4: A cacheable conditional store (`req_unc`=0) fails when the issuing context's reservation is invalid or names another block. A failure does not write memory and leaves that reservation invalid.
- R5: A cacheable conditional store returns the issuing context's valid bit as it stood before the check. The result is 1 on success, and also 1 on a block mismatch with a valid reservation. It is 0 when the reservation was invalid.
- R6: A conditional store with `req_unc`=1 always writes and returns result 2. It resets the issuing context's failure run and clears matching reservations as in R7.
- R7: Any write to memory (plain store, successful or uncacheable conditional store) invalidates the reservation of every context, the issuer included, whose block equals the written block.
- R8: Each failed cacheable conditional store adds one to the issuing context's failure run, and a success resets it to zero. When the run reaches a nonzero multiple of `WARN_PERIOD`, `warn_pulse` is 1 for one cycle with `warn_ctx` naming the context.
- R9: Outputs are registered. A request accepted at a rising edge produces `rsp_valid`=1 and its result, `mem_we` and `mem_addr` (equal to the request address) after that edge. Idle cycles give `rsp_valid`=0 and `mem_we`=0.
- R10: A plain load changes no reservation, returns result 0 and does not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_ctx | input | CTX_W | Issuing context |
| req_op | input | 2 | Operation code (see R2) |
| req_unc | input | 1 | Target address is uncacheable |
| req_addr | input | ADDR_W | Physical address |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_result | output | 2 | 0 fail/none, 1 pass, 2 uncacheable conditional |
| mem_we | output | 1 | Write enable to memory |
| mem_addr | output | ADDR_W | Address of the registered request |
| warn_pulse | output | 1 | Failure-run warning |
| warn_ctx | output | CTX_W | Context that raised the warning |

## Verification
The hardest case to reach from the ports is the warning pulse. It needs an unbroken run of failures on one context, while traffic from other contexts must not reset that run. The bench instantiates a small period and drives long failing streaks on one context. It breaks some streaks with a successful store and others with an uncacheable one, so both reset paths are exercised before the run starts counting again. A reservation that is valid but names the wrong block, which returns 1 yet does not write, is produced on purpose. Random mixed traffic over four shared blocks then covers cross-context clearing. Every cycle is compared against the bench's reference model.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_LLOAD = 2'd1,
    OP_STORE = 2'd2,
    OP_SCOND = 2'd3
  } mon_op_e;

  localparam logic [1:0] RES_FAIL = 2'd0;
  localparam logic [1:0] RES_PASS = 2'd1;
  localparam logic [1:0] RES_UNC  = 2'd2;
endpackage

// File: rtl/resv_slot.sv
module resv_slot #(
  parameter int BLK_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             snoop_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             valid_o,
  output logic             hit_o
);
  logic [BLK_W-1:0] blk_q;
  logic             valid_q;

  assign hit_o   = valid_q && (blk_q == blk_i);
  assign valid_o = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      blk_q   <= '0;
    end else if (clr_i || (snoop_i && hit_o)) begin
      valid_q <= 1'b0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      blk_q   <= blk_i;
    end
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i && !snoop_i) |=> valid_o); // R2

  AST_SNOOP_KILLS: assert property (@(posedge clk) disable iff (rst)
    (snoop_i && hit_o) |=> !valid_o); // R7
endmodule

// File: rtl/fail_tracker.sv
module fail_tracker #(
  parameter int WARN_PERIOD = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic fail_i,
  input  logic clear_i,
  output logic wrap_o
);
  localparam int PW = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(WARN_PERIOD - 1);

  logic [PW-1:0] phase_q;

  assign wrap_o = fail_i && (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear_i)   phase_q <= '0;
    else if (wrap_o)      phase_q <= '0;
    else if (fail_i)      phase_q <= phase_q + 1'b1;
  end

  AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (phase_q == '0)); // R8
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int NUM_CTX     = 4,
  parameter int ADDR_W      = 32,
  parameter int BLK_LSB     = 4,
  parameter int WARN_PERIOD = 100000,
  localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [1:0]        req_op,
  input  logic              req_unc,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_result,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              warn_pulse,
  output logic [CTX_W-1:0]  warn_ctx
);
  import resv_pkg::*;

  localparam int BLK_W = ADDR_W - BLK_LSB;

  logic [BLK_W-1:0]   req_blk;
  logic               is_ll, is_st, is_sc, sc_unc, sc_pass, sc_fail, write_go;
  logic               own_valid, own_hit;
  logic [NUM_CTX-1:0] slot_valid, slot_hit, ctx_sel, wrap;
  logic [1:0]         result_d;

  assign req_blk = req_addr[ADDR_W-1:BLK_LSB];
  assign is_ll   = req_valid && (req_op == OP_LLOAD);
  assign is_st   = req_valid && (req_op == OP_STORE);
  assign is_sc   = req_valid && (req_op == OP_SCOND);
  assign sc_unc  = is_sc && req_unc;

  always_comb begin
    own_valid = 1'b0;
    own_hit   = 1'b0;
    for (int i = 0; i < NUM_CTX; i++) begin
      ctx_sel[i] = (req_ctx == CTX_W'(i));
      if (ctx_sel[i]) begin
        own_valid = slot_valid[i];
        own_hit   = slot_hit[i];
      end
    end
  end

  assign sc_pass  = is_sc && !req_unc && own_hit;
  assign sc_fail  = is_sc && !req_unc && !own_hit;
  assign write_go = is_st || sc_unc || sc_pass;

  always_comb begin
    if (!is_sc)      result_d = RES_FAIL;
    else if (req_unc) result_d = RES_UNC;
    else             result_d = own_valid ? RES_PASS : RES_FAIL;
  end

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    resv_slot #(.BLK_W(BLK_W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .set_i  (is_ll && ctx_sel[g]),
      .clr_i  (sc_fail && ctx_sel[g]),
      .snoop_i(write_go),
      .blk_i  (req_blk),
      .valid_o(slot_valid[g]),
      .hit_o  (slot_hit[g])
    );

    fail_tracker #(.WARN_PERIOD(WARN_PERIOD)) u_trk (
      .clk    (clk),
      .rst    (rst),
      .fail_i (sc_fail && ctx_sel[g]),
      .clear_i((sc_pass || sc_unc) && ctx_sel[g]),
      .wrap_o (wrap[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_result <= RES_FAIL;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      warn_pulse <= 1'b0;
      warn_ctx   <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_result <= result_d;
      mem_we     <= write_go;
      mem_addr   <= req_addr;
      warn_pulse <= |wrap;
      warn_ctx   <= req_ctx;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R9

  AST_WRITE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(req_valid && req_op[1])); // R9

  AST_BLOCKED_SC_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (is_sc && !req_unc && !own_hit) |=> !mem_we); // R4

  AST_UNC_CODE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_result == RES_UNC) |-> $past(req_op == OP_SCOND && req_unc)); // R6

  AST_WARN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    warn_pulse |-> (rsp_valid && !mem_we && rsp_result != RES_UNC)); // R8
endmodule

// File: tb/resv_monitor_test.sv
`timescale 1ns/1ps
module resv_monitor_test;
  import resv_pkg::*;

  localparam int NC = 4;
  localparam int AW = 32;
  localparam int WP = 12;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [CW-1:0] req_ctx = '0;
  logic [1:0]    req_op = 2'd0;
  logic          req_unc = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid, mem_we, warn_pulse;
  logic [1:0]    rsp_result;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] warn_ctx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          m_flag [NC];
  logic [27:0] m_blk  [NC];
  int          m_fail [NC];

  always #2.5 clk = ~clk;

  resv_monitor #(.NUM_CTX(NC), .ADDR_W(AW), .BLK_LSB(4), .WARN_PERIOD(WP)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ctx(req_ctx),
    .req_op(req_op), .req_unc(req_unc), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_result(rsp_result), .mem_we(mem_we),
    .mem_addr(mem_addr), .warn_pulse(warn_pulse), .warn_ctx(warn_ctx));

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic idle(input string rq);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b0, rq, "idle rsp_valid", rsp_valid, 0);
    chk(mem_we == 1'b0, rq, "idle mem_we", mem_we, 0);
  endtask

  task automatic issue(input int c, input int op, input bit unc,
                       input logic [AW-1:0] a, input string rq);
    logic [27:0] b;
    bit          e_we, e_warn;
    logic [1:0]  e_res;
    bit          own;
    b = a[31:4];
    own = m_flag[c] && (m_blk[c] == b);
    e_we = 0; e_warn = 0; e_res = 2'd0;
    case (op)
      1: begin m_flag[c] = 1; m_blk[c] = b; end
      2: e_we = 1;
      3: begin
        if (unc) begin
          e_we = 1; e_res = 2'd2; m_fail[c] = 0;
        end else begin
          e_res = {1'b0, m_flag[c]};
          if (own) begin
            e_we = 1; m_fail[c] = 0;
          end else begin
            m_flag[c] = 0;
            m_fail[c]++;
            e_warn = (m_fail[c] % WP) == 0;
          end
        end
      end
      default: ;
    endcase
    if (e_we)
      for (int k = 0; k < NC; k++)
        if (m_flag[k] && m_blk[k] == b) m_flag[k] = 0;
    @(negedge clk);
    req_valid = 1'b1; req_ctx = CW'(c); req_op = 2'(op);
    req_unc = unc; req_addr = a;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b1, rq, "rsp_valid", rsp_valid, 1);
    chk(rsp_result == e_res, rq, "rsp_result", rsp_result, e_res);
    chk(mem_we == e_we, rq, "mem_we", mem_we, e_we);
    chk(mem_addr == a, rq, "mem_addr", mem_addr, a);
    chk(warn_pulse == e_warn, rq, "warn_pulse", warn_pulse, e_warn);
    if (e_warn) chk(warn_ctx == CW'(c), rq, "warn_ctx", warn_ctx, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NC; k++) begin m_flag[k] = 0; m_blk[k] = '0; m_fail[k] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 0 && mem_we == 0 && warn_pulse == 0 && rsp_result == 0,
        "R1", "reset outputs", {rsp_valid, mem_we, warn_pulse, rsp_result}, 0);
    @(negedge clk); rst = 1'b0;
    idle("R9");
    issue(0, 3, 0, 32'h100, "R1");     // no reservation after reset
    issue(0, 1, 0, 32'h100, "R2");
    issue(0, 0, 0, 32'h100, "R10");    // plain load leaves reservation
    issue(0, 3, 0, 32'h10C, "R3");     // same block, other offset: pass
    issue(0, 3, 0, 32'h100, "R7");     // own success cleared it
    issue(1, 1, 0, 32'h200, "R2");
    issue(2, 1, 0, 32'h204, "R2");
    issue(3, 1, 0, 32'h300, "R2");
    issue(0, 2, 0, 32'h20F, "R7");     // clears ctx1 and ctx2
    issue(1, 3, 0, 32'h200, "R7");
    issue(2, 3, 0, 32'h204, "R7");
    issue(3, 3, 0, 32'h300, "R7");     // untouched: pass
    issue(2, 1, 0, 32'h400, "R2");
    issue(2, 3, 0, 32'h410, "R5");     // valid but wrong block: result 1, no write
    issue(2, 3, 0, 32'h400, "R4");     // flag was dropped
    issue(1, 1, 0, 32'h500, "R2");
    issue(0, 3, 1, 32'h508, "R6");     // uncacheable: code 2, clears ctx1
    issue(1, 3, 0, 32'h500, "R6");
    for (int n = 0; n < WP; n++) issue(3, 3, 0, 32'h900, "R8");
    for (int n = 0; n < 5; n++) issue(3, 3, 0, 32'h900, "R8");
    issue(3, 3, 1, 32'h900, "R6");     // resets run
    for (int n = 0; n < WP; n++) issue(3, 3, 0, 32'h900, "R8");
    for (int n = 0; n < 7; n++) begin
      issue(1, 3, 0, 32'hA00, "R8");
      issue(2, 3, 0, 32'hA00, "R8");   // other context interleaved
    end
    issue(1, 1, 0, 32'hA00, "R8");
    issue(1, 3, 0, 32'hA04, "R8");     // success resets ctx1 run
    for (int n = 0; n < WP; n++) issue(1, 3, 0, 32'hA00, "R8");
    idle("R9");
    for (int n = 0; n < 3000; n++) begin
      int c, op;
      bit u;
      logic [AW-1:0] a;
      c  = $urandom_range(NC - 1);
      op = $urandom_range(3);
      u  = ($urandom_range(7) == 0);
      a  = {24'h0, 2'($urandom_range(3)), 2'b00, 4'($urandom_range(15))};
      issue(c, op, u, a, "R9");
      if ($urandom_range(15) == 0) idle("R9");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule